// File: doc/BRIEF.md
# Interrupt Daisy-Chain Priority Controller

This block is the interrupt section of a multi-channel serial peripheral that shares one request line with other devices. The devices are linked in a priority chain. Each channel has three interrupt sources: receive, transmit and status. The block merges their requests into one active-low open-drain request toward the CPU. It passes a priority enable down the chain to the next, lower-ranked device, or blocks it. It also answers the CPU's acknowledge cycle with a vector that names the winning source.

The block keeps one under-service bit per source. When the block wins an acknowledge cycle, the bit of the winning source is set as the cycle ends. A pending source raises a request only when no source of the same or higher rank is under service, so higher-ranked sources can nest over lower-ranked ones. A clear strobe from the CPU drops the highest-ranked under-service bit.

The data bus and the request line are left to the pad ring. The block provides the drive values and the drive enables for both.

Top module: `irq_chain_ctrl`

## Requirements
- R1: `irq_pull_low` is 1 exactly when `mie` is 1 and some bit of `src_req` is set that has no under-service bit at its own index or at any lower index. The request does not depend on `iei`.
- R2: Source index i = 3*channel + kind, where kind is receive=0, transmit=1, status=2. A lower index means a higher rank. An acknowledge cycle reports the lowest eligible index.
- R3: Outside an acknowledge cycle, `ieo` = `iei` AND (no under-service bit set). A request that is only pending does not block `ieo`.
- R4: During an acknowledge cycle, `ieo` is also forced low while `irq_pull_low` is 1.
- R5: `intack_n` is sampled on the rising clock edge. The acknowledge phase, including the vector drive, starts only in the cycle after the first edge that sees `intack_n` low.
- R6: The block wins an acknowledge cycle when, at the first sampled edge, `iei`=1 and `irq_pull_low`=1. During a won acknowledge cycle, while `iei`=1 and `rd_n`=0, `data_oe`=1 and `data_out` = {`vec_fixed`[4:1], index[2:0], `vec_fixed`[0]}. The index sits in bits 3:1. When `rd_n` is 1, `data_oe` is 0.
- R7: An acknowledge cycle with `iei`=0, with `mie`=0 or with no eligible source drives no vector and sets no under-service bit.
- R8: At the first edge that sees `intack_n` high again after a won cycle, the winner's under-service bit is set. From then on `ieo` is 0, and that source and every lower-ranked source stop raising `irq_pull_low`.
- R9: A one-cycle pulse on `clr_ius` clears only the lowest-index under-service bit that is set.
- R10: Outside an acknowledge phase, `ce_n`=0 together with `rd_n`=0 gives `data_oe`=1 and `data_out`=`reg_rdata`. In every other case outside a won acknowledge read, `data_oe` is 0.
- R11: A synchronous active-high `rst` clears every under-service bit and ends any acknowledge phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| src_req | input | 6 | Enabled pending requests, one per source, index 3*channel+kind |
| mie | input | 1 | Master interrupt enable |
| vec_fixed | input | 5 | Vector bits that are not replaced by the source code: bits 7:4 and bit 0 |
| reg_rdata | input | 8 | Register read data from the rest of the peripheral |
| iei | input | 1 | Chain enable from the higher-ranked neighbour |
| intack_n | input | 1 | Acknowledge strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| ce_n | input | 1 | Chip enable, active low |
| clr_ius | input | 1 | Clear-highest-under-service strobe |
| ieo | output | 1 | Chain enable to the lower-ranked neighbour |
| irq_pull_low | output | 1 | Open-drain request: 1 sinks the shared active-low line |
| data_out | output | 8 | Value for the tri-state data bus |
| data_oe | output | 1 | Drive enable for the tri-state data bus |

## Verification
The bench builds the block with its default of two channels. That gives six sources and a three-bit code in the vector. With these values both the top index 0 and the bottom index 5 are reachable as vectors, and nesting can be driven: a transmit source under service is overtaken by a receive source of the same channel. With two under-service bits set at once, the bench can show that a clear strobe removes only the higher-ranked bit.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

    localparam int SRC_PER_CH = 3;
    localparam int VEC_W      = 8;

    typedef enum logic [1:0] {
        SRC_RX = 2'd0,
        SRC_TX = 2'd1,
        SRC_ST = 2'd2
    } src_kind_e;

    typedef struct packed {
        logic active;
        logic won;
    } ack_state_t;

    function automatic int src_index(input int ch, input src_kind_e kind);
        return ch * SRC_PER_CH + int'(kind);
    endfunction

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int NSRC   = 6,
    parameter int CODE_W = 3
) (
    input  logic [NSRC-1:0]   req_i,
    input  logic [NSRC-1:0]   ius_i,
    output logic              any_o,
    output logic [CODE_W-1:0] code_o
);

    always_comb begin
        logic seen_ius;
        seen_ius = 1'b0;
        any_o    = 1'b0;
        code_o   = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (ius_i[i]) seen_ius = 1'b1;
            if (!any_o && !seen_ius && req_i[i]) begin
                any_o  = 1'b1;
                code_o = CODE_W'(i);
            end
        end
    end

    // R2: the reported code always names a source that is pending
    always_comb begin
        if (any_o) begin
            p_pick_pending_r2: assert (req_i[code_o]);
        end
    end

endmodule

// File: rtl/irq_ius_tracker.sv
module irq_ius_tracker #(
    parameter int NSRC   = 6,
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic [CODE_W-1:0] set_code,
    input  logic              clr,
    output logic [NSRC-1:0]   ius_o
);

    logic [NSRC-1:0] ius_q;
    logic [NSRC-1:0] lowest;

    assign lowest = ius_q & (~ius_q + NSRC'(1));
    assign ius_o  = ius_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                ius_q[i] <= 1'b0;
            else if (set_en && set_code == CODE_W'(i))
                ius_q[i] <= 1'b1;
            else if (clr && lowest[i])
                ius_q[i] <= 1'b0;
        end
    end

    p_ius_grow_one_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(ius_q) <= $countones($past(ius_q)) + 1));

    p_clear_one_r9: assert property (@(posedge clk) disable iff (rst)
        (clr && !set_en && (|ius_q)) |=>
        ($countones(ius_q) == $countones($past(ius_q)) - 1));

endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
    import irq_chain_pkg::*;
#(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              intack_n,
    input  logic              iei,
    input  logic              pend,
    input  logic [CODE_W-1:0] code_in,
    output logic              ack_active,
    output logic              ack_won,
    output logic [CODE_W-1:0] code_q,
    output logic              set_en
);

    ack_state_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= '0;
            code_q <= '0;
        end else begin
            st.active <= ~intack_n;
            if (!intack_n && !st.active) begin
                st.won <= iei && pend;
                code_q <= code_in;
            end else if (intack_n) begin
                st.won <= 1'b0;
            end
        end
    end

    assign ack_active = st.active;
    assign ack_won    = st.won;
    assign set_en     = st.active && intack_n && st.won;

    // R7: a win can only exist inside an acknowledge phase
    p_win_inside_ack_r7: assert property (@(posedge clk) disable iff (rst)
        st.won |-> st.active);

endmodule

// File: rtl/irq_chain_ctrl.sv
module irq_chain_ctrl
    import irq_chain_pkg::*;
#(
    parameter  int NUM_CH = 2,
    localparam int NSRC   = SRC_PER_CH * NUM_CH,
    localparam int CODE_W = $clog2(NSRC)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NSRC-1:0]         src_req,
    input  logic                    mie,
    input  logic [VEC_W-CODE_W-1:0] vec_fixed,
    input  logic [VEC_W-1:0]        reg_rdata,
    input  logic                    iei,
    input  logic                    intack_n,
    input  logic                    rd_n,
    input  logic                    ce_n,
    input  logic                    clr_ius,
    output logic                    ieo,
    output logic                    irq_pull_low,
    output logic [VEC_W-1:0]        data_out,
    output logic                    data_oe
);

    logic [NSRC-1:0]   ius;
    logic              any_elig;
    logic [CODE_W-1:0] top_code;
    logic              pend;
    logic              ack_active;
    logic              ack_won;
    logic [CODE_W-1:0] ack_code;
    logic              set_en;
    logic [VEC_W-1:0]  vector;

    irq_prio_enc #(.NSRC(NSRC), .CODE_W(CODE_W)) u_enc (
        .req_i  (src_req),
        .ius_i  (ius),
        .any_o  (any_elig),
        .code_o (top_code)
    );

    assign pend = mie && any_elig;

    irq_ack_ctrl #(.CODE_W(CODE_W)) u_ack (
        .clk        (clk),
        .rst        (rst),
        .intack_n   (intack_n),
        .iei        (iei),
        .pend       (pend),
        .code_in    (top_code),
        .ack_active (ack_active),
        .ack_won    (ack_won),
        .code_q     (ack_code),
        .set_en     (set_en)
    );

    irq_ius_tracker #(.NSRC(NSRC), .CODE_W(CODE_W)) u_ius (
        .clk      (clk),
        .rst      (rst),
        .set_en   (set_en),
        .set_code (ack_code),
        .clr      (clr_ius),
        .ius_o    (ius)
    );

    assign vector       = {vec_fixed[VEC_W-CODE_W-1:1], ack_code, vec_fixed[0]};
    assign irq_pull_low = pend;
    assign ieo          = iei && !(|ius) && !(ack_active && pend);
    assign data_oe      = (ack_active && ack_won && iei && !rd_n)
                        || (!ack_active && !ce_n && !rd_n);
    assign data_out     = ack_active ? vector : reg_rdata;

    p_ieo_needs_iei_r3: assert property (@(posedge clk) disable iff (rst)
        !iei |-> !ieo);

    p_busy_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        (|ius) |-> !ieo);

    p_ack_pend_blocks_r4: assert property (@(posedge clk) disable iff (rst)
        (ack_active && irq_pull_low) |-> !ieo);

    p_no_drive_without_read_r10: assert property (@(posedge clk) disable iff (rst)
        rd_n |-> !data_oe);

endmodule

// File: tb/irq_chain_ctrl_tb_top.sv
module irq_chain_ctrl_tb_top;
    import irq_chain_pkg::*;

    localparam int CLK_HALF = 10;
    localparam int MAX_CYC  = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] src_req = '0;
    logic       mie = 1'b1;
    logic [4:0] vec_fixed = 5'b10101;
    logic [7:0] reg_rdata = 8'h3C;
    logic       iei = 1'b1;
    logic       intack_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       ce_n = 1'b1;
    logic       clr_ius = 1'b0;
    logic       ieo;
    logic       irq_pull_low;
    logic [7:0] data_out;
    logic       data_oe;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    always #CLK_HALF clk = ~clk;

    irq_chain_ctrl dut_i (
        .clk(clk), .rst(rst), .src_req(src_req), .mie(mie),
        .vec_fixed(vec_fixed), .reg_rdata(reg_rdata), .iei(iei),
        .intack_n(intack_n), .rd_n(rd_n), .ce_n(ce_n), .clr_ius(clr_ius),
        .ieo(ieo), .irq_pull_low(irq_pull_low),
        .data_out(data_out), .data_oe(data_oe)
    );

    // columns: src_req[5:0], mie, iei, expected irq, expected ieo
    localparam logic [9:0] VECS [6] = '{
        {6'b000000, 1'b1, 1'b1, 1'b0, 1'b1},
        {6'b000001, 1'b1, 1'b1, 1'b1, 1'b1},
        {6'b100000, 1'b0, 1'b1, 1'b0, 1'b1},
        {6'b010000, 1'b1, 1'b0, 1'b1, 1'b0},
        {6'b111111, 1'b1, 1'b0, 1'b1, 1'b0},
        {6'b001000, 1'b1, 1'b1, 1'b1, 1'b1}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] vec_of(input int idx);
        return {vec_fixed[4:1], 3'(idx), vec_fixed[0]};
    endfunction

    task automatic do_ack(input logic exp_oe, input logic [7:0] exp_vec, input logic exp_ieo);
        tick();
        intack_n = 1'b0;
        rd_n     = 1'b0;
        #1 chk("R5 no drive before sampled", {7'd0, data_oe}, 8'd0);
        tick();
        #1 chk("R6 vector drive enable", {7'd0, data_oe}, {7'd0, exp_oe});
        if (exp_oe) chk("R6 R2 vector value", data_out, exp_vec);
        chk("R4 ieo during ack", {7'd0, ieo}, {7'd0, exp_ieo});
        rd_n = 1'b1;
        #1 chk("R6 no drive with read idle", {7'd0, data_oe}, 8'd0);
        tick();
        intack_n = 1'b1;
        tick();
    endtask

    initial begin
        repeat (2) tick();
        rst = 1'b0;
        #1;
        chk("R11 reset irq", {7'd0, irq_pull_low}, 8'd0);
        chk("R11 reset ieo", {7'd0, ieo}, 8'd1);
        chk("R11 reset bus", {7'd0, data_oe}, 8'd0);

        for (int k = 0; k < 6; k++) begin
            src_req = VECS[k][9:4];
            mie     = VECS[k][3];
            iei     = VECS[k][2];
            #2;
            chk("R1 request", {7'd0, irq_pull_low}, {7'd0, VECS[k][1]});
            chk("R3 ieo idle", {7'd0, ieo}, {7'd0, VECS[k][0]});
        end
        src_req = '0; mie = 1'b1; iei = 1'b1;

        tick();
        ce_n = 1'b0; rd_n = 1'b0;
        #1 chk("R10 register read oe", {7'd0, data_oe}, 8'd1);
        chk("R10 register read data", data_out, 8'h3C);
        ce_n = 1'b1;
        #1 chk("R10 deselected", {7'd0, data_oe}, 8'd0);
        rd_n = 1'b1;

        // transmit and status of channel A pending: transmit wins
        src_req = '0;
        src_req[src_index(0, SRC_TX)] = 1'b1;
        src_req[src_index(0, SRC_ST)] = 1'b1;
        do_ack(1'b1, vec_of(src_index(0, SRC_TX)), 1'b0);
        chk("R8 ieo after win", {7'd0, ieo}, 8'd0);
        chk("R8 equal and lower blocked", {7'd0, irq_pull_low}, 8'd0);
        src_req[src_index(0, SRC_RX)] = 1'b1;
        #1 chk("R1 higher source nests", {7'd0, irq_pull_low}, 8'd1);
        do_ack(1'b1, vec_of(0), 1'b0);
        chk("R8 all blocked", {7'd0, irq_pull_low}, 8'd0);

        tick();
        clr_ius = 1'b1;
        tick();
        clr_ius = 1'b0;
        #1 chk("R9 highest cleared", {7'd0, irq_pull_low}, 8'd1);
        chk("R9 lower still held", {7'd0, ieo}, 8'd0);
        clr_ius = 1'b1;
        tick();
        clr_ius = 1'b0;
        #1 chk("R9 second clear", {7'd0, ieo}, 8'd1);

        // lowest-ranked source, chain enable low: lost
        src_req = 6'b100000;
        iei = 1'b0;
        do_ack(1'b0, 8'h00, 1'b0);
        iei = 1'b1;
        #1 chk("R7 lost ack sets nothing", {7'd0, ieo}, 8'd1);
        do_ack(1'b1, vec_of(src_index(1, SRC_ST)), 1'b0);
        chk("R8 bottom source served", {7'd0, ieo}, 8'd0);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        #1 chk("R11 reset clears service", {7'd0, ieo}, 8'd1);

        mie = 1'b0;
        do_ack(1'b0, 8'h00, 1'b1);
        chk("R7 masked ack sets nothing", {7'd0, ieo}, 8'd1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        #(2 * CLK_HALF * MAX_CYC);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

endmodule